// File: doc/BRIEF.md
# Timer Capture Channel with Triggers

This block is one channel of a timer used for measurement. A free-running counter advances on every system clock and is sent back to zero by any of four triggers: a software strobe, a sync strobe shared by all channels, a match against a programmable compare value, or a selected edge on one of the two external pins. Chosen edges on pin A copy the counter into capture register A or capture register B. The two registers are interlocked so that they fill in strict alternation, A first after every trigger.

Each capture raises a one-cycle DMA request. Per-register unread tracking detects overruns. A combined read port gives the oldest capture that has not yet been read, taken from a two-entry ordered queue, so a consumer can drain A and B values in the order they arrived. Sticky status flags report loads, overruns and counter wrap, and one status read clears all of them.

The alternation is a two-state machine. In state ARM_A only register A may load. In state ARM_B only register B may load. It has three transitions. LOAD_A goes from ARM_A to ARM_B on an accepted A edge. LOAD_B goes from ARM_B to ARM_A on an accepted B edge. TRIGGER goes from either state to ARM_A.

Top module: `cap_timer_chan`

## Requirements
- R1: The counter resets to 0 and then increments by one on every clock. It wraps from 0xFFFF to 0, and that wrap sets the sticky flag `flg_cov`.
- R2: A high `sw_trig` or `sync_trig` in a cycle makes `count` read 0 after the next clock edge.
- R3: When `rc_trig_en` is 1 and `count` equals `rc_value`, the next count is 0, so the count repeats with period `rc_value`+1.
- R4: When `ext_trig_en` is 1, an edge on the selected pin acts as a trigger. `ext_src_sel` selects the pin: 0 is pin_a, 1 is pin_b. `ext_edge_sel` selects the edge, with the encoding 00 none, 01 rising, 10 falling, 11 both. Pins pass through a two-flop synchronizer. A pin change that is set up before clock edge E gives `count`=0 after edge E+2. An edge on the other pin, or an edge that is not selected, has no effect.
- R5: `lda_edge_sel` and `ldb_edge_sel` use the same encoding to select which pin_a edges load register A and register B. A pin_a change set up before edge E loads, at edge E+2, the value `count` held between edges E+1 and E+2.
- R6: Register A loads only in state ARM_A. That state is entered at reset, after a trigger, or after B has loaded. Further A edges after an A load are ignored until B loads.
- R7: Register B loads only in state ARM_B, which is entered when A loads. B edges are ignored after a trigger until A has loaded.
- R8: A trigger in the same cycle as a capture edge wins. No capture happens, and the interlock returns to ARM_A.
- R9: A load into a register whose previous value is unread overwrites it and sets the sticky flag `flg_ovr`. A value counts as read after `rd_cap_a`, `rd_cap_b`, or `rd_comb` while it is at the head of the queue.
- R10: `flg_lda` and `flg_ldb` set on loads of A and B. A pulse on `rd_status` clears `flg_lda`, `flg_ldb`, `flg_ovr` and `flg_cov`. A flag being set in the same cycle wins over the clear.
- R11: `comb_data` and `comb_valid` show the oldest unread capture. `rd_comb` removes that entry. Reading A or B directly, or reloading a register, removes that register's older entry.
- R12: Each load drives `dma_req` high for exactly one cycle, in the same cycle the new value appears on `cap_a` or `cap_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_trig | input | 1 | Software trigger strobe |
| sync_trig | input | 1 | Sync strobe shared by all channels |
| rc_trig_en | input | 1 | Enable compare-match trigger |
| rc_value | input | 16 | Compare value |
| ext_trig_en | input | 1 | Enable external trigger |
| ext_src_sel | input | 1 | External trigger pin: 0 pin_a, 1 pin_b |
| ext_edge_sel | input | 2 | External trigger edge select |
| lda_edge_sel | input | 2 | pin_a edge select for register A |
| ldb_edge_sel | input | 2 | pin_a edge select for register B |
| pin_a | input | 1 | External input A (asynchronous) |
| pin_b | input | 1 | External input B (asynchronous) |
| rd_status | input | 1 | Status read strobe, clears the flags |
| rd_cap_a | input | 1 | Read strobe for register A |
| rd_cap_b | input | 1 | Read strobe for register B |
| rd_comb | input | 1 | Read strobe for the combined port |
| count | output | 16 | Counter value |
| cap_a | output | 16 | Capture register A |
| cap_b | output | 16 | Capture register B |
| comb_data | output | 16 | Oldest unread capture |
| comb_valid | output | 1 | comb_data holds an unread value |
| flg_lda | output | 1 | Sticky: A loaded |
| flg_ldb | output | 1 | Sticky: B loaded |
| flg_ovr | output | 1 | Sticky: overrun |
| flg_cov | output | 1 | Sticky: counter wrapped |
| dma_req | output | 1 | One-cycle request per load |

## Verification
The hardest situation to reach from the ports is a capture edge and a trigger landing in the same synchronized cycle, since both take three clock edges to travel from the pins. The bench gets there by making pin_a both the external trigger source and the A capture edge, so a single rising edge produces both in the same cycle. It then checks that no load, flag or DMA request follows. The blocked-load cases need the interlock held in one state while edges of the refused kind arrive. The stimulus reaches them by toggling pin_a with only one edge selection active. A scoreboard fails on any DMA request that was not expected.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_sel_e;

    typedef enum logic {
        ARM_A = 1'b0,
        ARM_B = 1'b1
    } ilk_state_e;

    typedef enum logic {
        TAG_A = 1'b0,
        TAG_B = 1'b1
    } cap_tag_e;

    function automatic logic edge_match(input logic [1:0] sel,
                                        input logic rise,
                                        input logic fall);
        return (sel[0] & rise) | (sel[1] & fall);
    endfunction

endpackage

// File: rtl/cap_edge_sync.sv
module cap_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], din};
            prev_q <= sync_q[TOP];
        end
    end

    assign rise = sync_q[TOP] & ~prev_q;
    assign fall = ~sync_q[TOP] & prev_q;

endmodule

// File: rtl/cap_interlock.sv
module cap_interlock
    import cap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic ev_a,
    input  logic ev_b,
    output logic ld_a,
    output logic ld_b
);
    ilk_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ARM_A;
        else        state_q <= state_d;
    end

    // Next state: TRIGGER overrides LOAD_A / LOAD_B
    always_comb begin
        state_d = state_q;
        if (trig) begin
            state_d = ARM_A;
        end else begin
            unique case (state_q)
                ARM_A: if (ev_a) state_d = ARM_B;
                ARM_B: if (ev_b) state_d = ARM_A;
            endcase
        end
    end

    // Outputs
    always_comb begin
        ld_a = 1'b0;
        ld_b = 1'b0;
        if (!trig) begin
            unique case (state_q)
                ARM_A: ld_a = ev_a;
                ARM_B: ld_b = ev_b;
            endcase
        end
    end

    // R6: after an A load, A cannot load again in the next cycle
    assert_a_alternates_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ld_a |=> !ld_a);

    // R7: after a B load, B cannot load again in the next cycle
    assert_b_alternates_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_b |=> !ld_b);

endmodule

// File: rtl/cap_order_q.sv
module cap_order_q
    import cap_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  cap_tag_e          push_tag,
    input  logic [DATA_W-1:0] push_data,
    input  logic              del_a,
    input  logic              del_b,
    output logic              head_valid,
    output cap_tag_e          head_tag,
    output logic [DATA_W-1:0] head_data
);
    localparam int DEPTH = 2;

    logic [DEPTH-1:0] v_q, v_d, keep;
    cap_tag_e         t_q [DEPTH];
    cap_tag_e         t_d [DEPTH];
    logic [DATA_W-1:0] d_q [DEPTH];
    logic [DATA_W-1:0] d_d [DEPTH];
    logic drop_a, drop_b;

    always_comb begin
        // a reload replaces the register's older entry
        drop_a = del_a | (push & (push_tag == TAG_A));
        drop_b = del_b | (push & (push_tag == TAG_B));
        for (int i = 0; i < DEPTH; i++)
            keep[i] = v_q[i] & ~((t_q[i] == TAG_A) ? drop_a : drop_b);

        v_d = '0;
        for (int i = 0; i < DEPTH; i++) begin
            t_d[i] = TAG_A;
            d_d[i] = '0;
        end
        // compact surviving entries toward the head
        if (keep[0]) begin
            v_d[0] = 1'b1; t_d[0] = t_q[0]; d_d[0] = d_q[0];
            if (keep[1]) begin
                v_d[1] = 1'b1; t_d[1] = t_q[1]; d_d[1] = d_q[1];
            end
        end else if (keep[1]) begin
            v_d[0] = 1'b1; t_d[0] = t_q[1]; d_d[0] = d_q[1];
        end
        // append
        if (push) begin
            if (!v_d[0]) begin
                v_d[0] = 1'b1; t_d[0] = push_tag; d_d[0] = push_data;
            end else begin
                v_d[1] = 1'b1; t_d[1] = push_tag; d_d[1] = push_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                t_q[i] <= TAG_A;
                d_q[i] <= '0;
            end
        end else begin
            v_q <= v_d;
            for (int i = 0; i < DEPTH; i++) begin
                t_q[i] <= t_d[i];
                d_q[i] <= d_d[i];
            end
        end
    end

    assign head_valid = v_q[0];
    assign head_tag   = t_q[0];
    assign head_data  = d_q[0];

    // R11: one tag per entry means a push always finds room
    assert_q_room_R11: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !(keep[0] && keep[1]));

    // R11: a pushed value is visible at the head on the next cycle
    assert_q_push_visible_R11: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> head_valid);

endmodule

// File: rtl/cap_timer_chan.sv
module cap_timer_chan
    import cap_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_trig,
    input  logic             sync_trig,
    input  logic             rc_trig_en,
    input  logic [CNT_W-1:0] rc_value,
    input  logic             ext_trig_en,
    input  logic             ext_src_sel,
    input  logic [1:0]       ext_edge_sel,
    input  logic [1:0]       lda_edge_sel,
    input  logic [1:0]       ldb_edge_sel,
    input  logic             pin_a,
    input  logic             pin_b,
    input  logic             rd_status,
    input  logic             rd_cap_a,
    input  logic             rd_cap_b,
    input  logic             rd_comb,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cap_a,
    output logic [CNT_W-1:0] cap_b,
    output logic [CNT_W-1:0] comb_data,
    output logic             comb_valid,
    output logic             flg_lda,
    output logic             flg_ldb,
    output logic             flg_ovr,
    output logic             flg_cov,
    output logic             dma_req
);
    localparam int N_PINS = 2;

    logic [N_PINS-1:0] pins, rise_v, fall_v;
    logic ext_hit, rc_hit, trig, wrap;
    logic ev_a, ev_b, ld_a, ld_b;
    logic del_a, del_b, unread_a_q, unread_b_q, ovr_set;
    cap_tag_e head_tag;

    assign pins = {pin_b, pin_a};

    generate
        for (genvar g = 0; g < N_PINS; g++) begin : g_pin
            cap_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (pins[g]),
                .rise (rise_v[g]),
                .fall (fall_v[g])
            );
        end
    endgenerate

    // trigger sources
    assign ext_hit = ext_trig_en &
                     edge_match(ext_edge_sel, rise_v[ext_src_sel], fall_v[ext_src_sel]);
    assign rc_hit  = rc_trig_en & (count == rc_value);
    assign trig    = sw_trig | sync_trig | rc_hit | ext_hit;
    assign wrap    = ~trig & (count == {CNT_W{1'b1}});

    // capture edge events on pin A
    assign ev_a = edge_match(lda_edge_sel, rise_v[0], fall_v[0]);
    assign ev_b = edge_match(ldb_edge_sel, rise_v[0], fall_v[0]);

    cap_interlock u_ilk (
        .clk  (clk),
        .rst_n(rst_n),
        .trig (trig),
        .ev_a (ev_a),
        .ev_b (ev_b),
        .ld_a (ld_a),
        .ld_b (ld_b)
    );

    // read bookkeeping
    assign del_a = rd_cap_a | (rd_comb & comb_valid & (head_tag == TAG_A));
    assign del_b = rd_cap_b | (rd_comb & comb_valid & (head_tag == TAG_B));
    assign ovr_set = (ld_a & unread_a_q & ~del_a) | (ld_b & unread_b_q & ~del_b);

    cap_order_q #(.DATA_W(CNT_W)) u_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ld_a | ld_b),
        .push_tag  (ld_b ? TAG_B : TAG_A),
        .push_data (count),
        .del_a     (del_a),
        .del_b     (del_b),
        .head_valid(comb_valid),
        .head_tag  (head_tag),
        .head_data (comb_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count      <= '0;
            cap_a      <= '0;
            cap_b      <= '0;
            unread_a_q <= 1'b0;
            unread_b_q <= 1'b0;
            flg_lda    <= 1'b0;
            flg_ldb    <= 1'b0;
            flg_ovr    <= 1'b0;
            flg_cov    <= 1'b0;
            dma_req    <= 1'b0;
        end else begin
            count      <= trig ? '0 : count + 1'b1;
            if (ld_a) cap_a <= count;
            if (ld_b) cap_b <= count;
            unread_a_q <= ld_a | (unread_a_q & ~del_a);
            unread_b_q <= ld_b | (unread_b_q & ~del_b);
            flg_lda    <= ld_a    | (flg_lda & ~rd_status);
            flg_ldb    <= ld_b    | (flg_ldb & ~rd_status);
            flg_ovr    <= ovr_set | (flg_ovr & ~rd_status);
            flg_cov    <= wrap    | (flg_cov & ~rd_status);
            dma_req    <= ld_a | ld_b;
        end
    end

    // R2: any trigger zeroes the counter on the next edge
    assert_trig_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (count == '0));

    // R1: wrap from all ones to zero sets the overflow flag
    assert_wrap_cov_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (count == {CNT_W{1'b1}} && !trig) |=> (count == '0 && flg_cov));

    // R12: each load is followed by a DMA request
    assert_dma_follows_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_a || ld_b) |=> dma_req);

    // R9: the overrun flag only rises after a load
    assert_ovr_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flg_ovr) |-> $past(ld_a || ld_b));

    // R8: no load in a cycle carrying a trigger
    assert_trig_blocks_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> !(ld_a || ld_b));

endmodule

// File: tb/test_cap_timer_chan.sv
module test_cap_timer_chan;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_trig = 0, sync_trig = 0, rc_trig_en = 0, ext_trig_en = 0, ext_src_sel = 0;
    logic [15:0] rc_value = '0;
    logic [1:0] ext_edge_sel = '0, lda_edge_sel = '0, ldb_edge_sel = '0;
    logic pin_a = 0, pin_b = 0;
    logic rd_status = 0, rd_cap_a = 0, rd_cap_b = 0, rd_comb = 0;
    logic [15:0] count, cap_a, cap_b, comb_data;
    logic comb_valid, flg_lda, flg_ldb, flg_ovr, flg_cov, dma_req;

    int n_tests = 0;
    int n_fail  = 0;
    int tb_cyc  = 0;
    int p0      = 0;
    logic [16:0] exp_q[$];   // bit 16: 1 = register B

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) tb_cyc++;

    cap_timer_chan i_cap_timer_chan (
        .clk(clk), .rst_n(rst_n), .sw_trig(sw_trig), .sync_trig(sync_trig),
        .rc_trig_en(rc_trig_en), .rc_value(rc_value), .ext_trig_en(ext_trig_en),
        .ext_src_sel(ext_src_sel), .ext_edge_sel(ext_edge_sel),
        .lda_edge_sel(lda_edge_sel), .ldb_edge_sel(ldb_edge_sel),
        .pin_a(pin_a), .pin_b(pin_b), .rd_status(rd_status), .rd_cap_a(rd_cap_a),
        .rd_cap_b(rd_cap_b), .rd_comb(rd_comb), .count(count), .cap_a(cap_a),
        .cap_b(cap_b), .comb_data(comb_data), .comb_valid(comb_valid),
        .flg_lda(flg_lda), .flg_ldb(flg_ldb), .flg_ovr(flg_ovr), .flg_cov(flg_cov),
        .dma_req(dma_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: every DMA request must match the next expected capture (R12, R5)
    always @(negedge clk) begin
        if (rst_n && dma_req) begin
            if (exp_q.size() == 0) begin
                check("R12 unexpected dma_req", 1, 0);
            end else begin
                logic [16:0] it;
                it = exp_q.pop_front();
                if (it[16]) check("R5 cap_b value", {16'd0, cap_b}, {16'd0, it[15:0]});
                else        check("R5 cap_a value", {16'd0, cap_a}, {16'd0, it[15:0]});
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_trig();
        sw_trig = 1'b1;
        p0 = tb_cyc + 1;
        @(negedge clk);
        sw_trig = 1'b0;
    endtask

    // Drive pin_a; when a load is expected, push its tag and value to the scoreboard
    task automatic drive_a(input logic lvl, input bit expect_ld, input bit is_b,
                           output logic [15:0] val);
        val = 16'(tb_cyc + 2 - p0);
        pin_a = lvl;
        if (expect_ld) exp_q.push_back({is_b, val});
        idle(4);
    endtask

    task automatic pulse(input int which);
        case (which)
            0: rd_status = 1'b1;
            1: rd_cap_a  = 1'b1;
            2: rd_cap_b  = 1'b1;
            default: rd_comb = 1'b1;
        endcase
        @(negedge clk);
        rd_status = 0; rd_cap_a = 0; rd_cap_b = 0; rd_comb = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] va1, vb1, va2, vb2, va3, vb3, va4, va5, va6, vb6, dummy;
        idle(3);
        // R1: reset state
        check("R1 count in reset", {16'd0, count}, 0);
        check("R10 flags in reset", {28'd0, flg_lda, flg_ldb, flg_ovr, flg_cov}, 0);
        check("R11 comb_valid in reset", {31'd0, comb_valid}, 0);
        check("R12 dma_req in reset", {31'd0, dma_req}, 0);
        rst_n = 1'b1;
        idle(2);

        // R5 R6 R7: A on rising, B on falling, alternate
        lda_edge_sel = 2'b01; ldb_edge_sel = 2'b10;
        do_trig(); idle(5);
        drive_a(1, 1, 0, va1);
        drive_a(0, 1, 1, vb1);
        check("R5 cap_a after rise", {16'd0, cap_a}, {16'd0, va1});
        check("R5 cap_b after fall", {16'd0, cap_b}, {16'd0, vb1});
        check("R10 load flags set", {30'd0, flg_lda, flg_ldb}, 3);
        pulse(0);
        check("R10 flags cleared by status read", {29'd0, flg_lda, flg_ldb, flg_ovr}, 0);

        // R11: combined port order
        check("R11 comb head is A", {15'd0, comb_valid, comb_data}, {15'd0, 1'b1, va1});
        pulse(3);
        check("R11 comb next is B", {15'd0, comb_valid, comb_data}, {15'd0, 1'b1, vb1});
        pulse(3);
        check("R11 comb empty", {31'd0, comb_valid}, 0);

        // R9: overrun on an unread A
        drive_a(1, 1, 0, va2);
        drive_a(0, 1, 1, vb2);
        drive_a(1, 1, 0, va3);
        check("R9 overrun set", {31'd0, flg_ovr}, 1);
        check("R9 A overwritten", {16'd0, cap_a}, {16'd0, va3});
        pulse(0);
        check("R9 overrun cleared", {31'd0, flg_ovr}, 0);
        pulse(1); pulse(2);
        drive_a(0, 1, 1, vb3);
        check("R9 no overrun after read", {31'd0, flg_ovr}, 0);
        check("R11 comb holds only B", {15'd0, comb_valid, comb_data}, {15'd0, 1'b1, vb3});
        pulse(3);

        // R6: A blocked until B loads
        ldb_edge_sel = 2'b00;
        drive_a(1, 1, 0, va4);
        drive_a(0, 0, 0, dummy);
        drive_a(1, 0, 0, dummy);
        check("R6 A blocked without B", {16'd0, cap_a}, {16'd0, va4});

        // R8: trigger rearms A
        do_trig();
        drive_a(0, 0, 0, dummy);
        drive_a(1, 1, 0, va5);
        check("R8 A loads after trigger", {16'd0, cap_a}, {16'd0, va5});

        // R7: B blocked after trigger until A loads
        do_trig();
        lda_edge_sel = 2'b00; ldb_edge_sel = 2'b01;
        drive_a(0, 0, 0, dummy);
        drive_a(1, 0, 0, dummy);
        check("R7 B blocked before A", {16'd0, cap_b}, {16'd0, vb3});
        lda_edge_sel = 2'b01;
        drive_a(0, 0, 0, dummy);
        drive_a(1, 1, 0, va6);
        drive_a(0, 0, 0, dummy);
        drive_a(1, 1, 1, vb6);
        check("R7 B loads after A", {16'd0, cap_b}, {16'd0, vb6});
        pulse(1); pulse(2); pulse(0);

        // R2: sync strobe
        idle(7);
        sync_trig = 1'b1; p0 = tb_cyc + 1;
        @(negedge clk); sync_trig = 1'b0;
        check("R2 sync zeroes count", {16'd0, count}, 0);
        idle(3);
        check("R2 count runs after sync", {16'd0, count}, 3);

        // R3: compare trigger
        rc_value = 16'd20; rc_trig_en = 1'b1;
        do_trig(); idle(20);
        check("R3 count reaches RC", {16'd0, count}, 20);
        idle(1);
        check("R3 count restarts after RC", {16'd0, count}, 0);
        idle(29);
        check("R3 period RC+1", {16'd0, count}, 8);
        rc_trig_en = 1'b0;

        // R4: external trigger on pin_b rising
        lda_edge_sel = 2'b00; ldb_edge_sel = 2'b00;
        ext_trig_en = 1'b1; ext_src_sel = 1'b1; ext_edge_sel = 2'b01;
        do_trig();
        drive_a(0, 0, 0, dummy);
        drive_a(1, 0, 0, dummy);
        check("R4 pin_a ignored when pin_b selected", {16'd0, count}, 32'(tb_cyc - p0));
        pin_b = 1'b1; idle(5);
        check("R4 pin_b rise triggers", {16'd0, count}, 2);
        pin_b = 1'b0; idle(6);
        check("R4 unselected fall ignored", {16'd0, count}, 8);

        // R8: trigger and capture on the same pin_a edge
        ext_src_sel = 1'b0; lda_edge_sel = 2'b01;
        do_trig();
        drive_a(0, 0, 0, dummy);
        pulse(0);
        drive_a(1, 0, 0, dummy);
        check("R8 no capture with trigger", {16'd0, cap_a}, {16'd0, va6});
        check("R8 no load flag with trigger", {31'd0, flg_lda}, 0);
        check("R4 pin_a edge restarts count", {16'd0, count}, 1);
        ext_trig_en = 1'b0; lda_edge_sel = 2'b00;

        // R1: wrap and overflow flag
        pulse(0);
        do_trig(); idle(65530);
        check("R1 count before wrap", {16'd0, count}, 65530);
        check("R1 no overflow yet", {31'd0, flg_cov}, 0);
        idle(10);
        check("R1 count wrapped", {16'd0, count}, 4);
        check("R1 overflow flag", {31'd0, flg_cov}, 1);
        pulse(0);
        check("R10 overflow cleared", {31'd0, flg_cov}, 0);

        check("R12 all expected loads seen", exp_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule